// File: doc/BRIEF.md
# Two-Wire Serial Byte Memory Slave

This block is a slave on a two-wire serial bus (I2C style, 7-bit addressing) that fronts a small byte array held on chip. It oversamples the clock and data lines with the system clock, detects start and stop conditions, and decodes the slave address byte. The address byte is compared partly against a fixed prefix and partly against strap inputs. On a match the block acknowledges and then writes bytes into the array or reads bytes out of it.

A write transfer carries the device address with the direction bit at 0, then one pointer byte, then any number of data bytes. Each data byte lands at the pointer, and the pointer then moves forward. A read transfer with the direction bit at 1 streams bytes from the current pointer until the master declines a byte. A write-protect input blocks every array update without changing anything the master sees on the bus. The data line is open drain, so the block only reports when it pulls the line low.

Top module: `i2c_mem_slave`

## Requirements
- R1: A falling data line while the clock is high (a start) begins reception of a new address byte from any state, including in the middle of a byte. The aborted byte is discarded and nothing is written from it.
- R2: A rising data line while the clock is high (a stop) returns the block to idle and releases the data line. A data byte that is not yet complete is not written.
- R3: The address byte is received MSB first. Bits 7..4 must be 1010, bit 3 must be 1, bits 2..1 must equal `sel_a[1:0]`, and bit 0 is the direction (1 read, 0 write). On a match the block pulls the data line low (`sda_oe`=1) for the ninth clock.
- R4: On an address mismatch the block does not acknowledge, and it ignores all further clocks until the next start.
- R5: While `sel_fixed` is low the block acknowledges no address, whatever the address bits are.
- R6: In a write transfer, the first byte after the address is acknowledged. Its low log2(MEM_DEPTH) bits load the pointer.
- R7: Each later data byte of a write transfer is acknowledged and stored at the pointer. The pointer then increments, wrapping modulo MEM_DEPTH.
- R8: While `wp` is high, data bytes are still acknowledged and the pointer still advances, but the array keeps its contents.
- R9: In a read transfer, the byte at the pointer is driven MSB first, with `sda_oe` equal to the inverse of each bit. The first bit is driven after the falling clock that ends the address acknowledge, and each later bit after a falling clock. The pointer increments after each byte.
- R10: A master that leaves the data line high on the ninth clock of a read byte (NACK) ends the read. The block releases the line and stays silent until the next start.
- R11: `sda_oe` changes only while the clock line is low.
- R12: After reset, `sda_oe` is 0 and the block is idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than the bus clock |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | Bus clock line as seen on the bus |
| sda_i | input | 1 | Data line as seen on the bus (wired-AND of all drivers) |
| sel_a | input | 2 | Configurable strap bits compared with address bits 2..1 |
| sel_fixed | input | 1 | Fixed strap; the block responds only while it is high |
| wp | input | 1 | Write protect; high blocks array updates |
| sda_oe | output | 1 | 1 pulls the data line low, 0 releases it |

## Verification
The bench goes after aborted bytes, where a start or a stop lands part way through a data byte. A design that commits partial shift contents would corrupt a location that a later read exposes. It also tests pointer wrap at the last location: a design that ran past the array or failed to wrap would return the wrong second byte. Under write protect the bench demands acknowledges together with unchanged read-back, which catches both a design that NACKs and one that still writes. Finally it clocks a further byte after a master NACK and requires all ones, which exposes a slave that keeps driving data. Address decoding is tested with a wrong strap match, a cleared fixed bit in the address, and a low fixed strap pin.

// File: rtl/i2cm_pkg.sv
package i2cm_pkg;
  localparam logic [3:0] DEV_PREFIX = 4'b1010;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_DEVADDR,
    ST_DEVACK,
    ST_PTR,
    ST_PTRACK,
    ST_WR,
    ST_WRACK,
    ST_TX,
    ST_MACK
  } bus_state_t;
endpackage

// File: rtl/i2cm_sync.sv
module i2cm_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_s,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);
  logic [STAGES-1:0] scl_pipe;
  logic [STAGES-1:0] sda_pipe;
  logic              scl_d;
  logic              sda_d;

  always_ff @(posedge clk) begin
    if (rst) begin
      scl_pipe <= '1;
      sda_pipe <= '1;
      scl_d    <= 1'b1;
      sda_d    <= 1'b1;
    end else begin
      scl_pipe <= {scl_pipe[STAGES-2:0], scl_i};
      sda_pipe <= {sda_pipe[STAGES-2:0], sda_i};
      scl_d    <= scl_pipe[STAGES-1];
      sda_d    <= sda_pipe[STAGES-1];
    end
  end

  assign scl_s     = scl_pipe[STAGES-1];
  assign sda_s     = sda_pipe[STAGES-1];
  assign scl_rise  = scl_s & ~scl_d;
  assign scl_fall  = ~scl_s & scl_d;
  // data edges only count as framing while the clock stays high
  assign start_det = scl_s & scl_d & sda_d & ~sda_s;
  assign stop_det  = scl_s & scl_d & ~sda_d & sda_s;
endmodule

// File: rtl/i2cm_mem.sv
module i2cm_mem #(
  parameter int DEPTH = 16,
  parameter int DW    = 8,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  logic [DW-1:0] cells [DEPTH];

  always_ff @(posedge clk) begin
    if (we) cells[waddr] <= wdata;
    rdata <= cells[raddr];
  end
endmodule

// File: rtl/i2cm_fsm.sv
module i2cm_fsm
  import i2cm_pkg::*;
#(
  parameter int AW = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          scl_rise,
  input  logic          scl_fall,
  input  logic          start_det,
  input  logic          stop_det,
  input  logic          sda_s,
  input  logic [1:0]    sel_a,
  input  logic          sel_fixed,
  input  logic [7:0]    rd_data,
  output logic          sda_oe,
  output logic          wr_req,
  output logic [7:0]    wr_data,
  output logic [AW-1:0] ptr,
  output bus_state_t    state
);
  logic [3:0] cnt_q;
  logic [7:0] sh_q;
  logic [7:0] tx_q;
  logic       addr_hit;
  logic       rx_state;

  assign addr_hit = (sh_q[7:4] == DEV_PREFIX) && sh_q[3] && sel_fixed &&
                    (sh_q[2:1] == sel_a);
  assign rx_state = (state == ST_DEVADDR) || (state == ST_PTR) || (state == ST_WR);

  always_ff @(posedge clk) begin
    if (rst) begin
      state   <= ST_IDLE;
      cnt_q   <= '0;
      sh_q    <= '0;
      tx_q    <= '0;
      sda_oe  <= 1'b0;
      wr_req  <= 1'b0;
      wr_data <= '0;
      ptr     <= '0;
    end else begin
      wr_req <= 1'b0;
      if (start_det) begin
        state  <= ST_DEVADDR;
        cnt_q  <= '0;
        sda_oe <= 1'b0;
      end else if (stop_det) begin
        state  <= ST_IDLE;
        cnt_q  <= '0;
        sda_oe <= 1'b0;
      end else if (rx_state) begin
        if (scl_rise && cnt_q != 4'd8) begin
          sh_q  <= {sh_q[6:0], sda_s};
          cnt_q <= cnt_q + 4'd1;
        end else if (scl_fall && cnt_q == 4'd8) begin
          cnt_q <= '0;
          if (state == ST_DEVADDR) begin
            if (addr_hit) begin
              sda_oe <= 1'b1;
              state  <= ST_DEVACK;
            end else begin
              state  <= ST_IDLE;
            end
          end else if (state == ST_PTR) begin
            sda_oe <= 1'b1;
            ptr    <= sh_q[AW-1:0];
            state  <= ST_PTRACK;
          end else begin
            sda_oe  <= 1'b1;
            wr_req  <= 1'b1;
            wr_data <= sh_q;
            state   <= ST_WRACK;
          end
        end
      end else begin
        case (state)
          ST_DEVACK: if (scl_fall) begin
            cnt_q <= '0;
            if (sh_q[0]) begin
              tx_q   <= {rd_data[6:0], 1'b0};
              sda_oe <= ~rd_data[7];
              state  <= ST_TX;
            end else begin
              sda_oe <= 1'b0;
              state  <= ST_PTR;
            end
          end
          ST_PTRACK: if (scl_fall) begin
            sda_oe <= 1'b0;
            state  <= ST_WR;
          end
          ST_WRACK: if (scl_fall) begin
            sda_oe <= 1'b0;
            ptr    <= ptr + 1'b1;
            state  <= ST_WR;
          end
          ST_TX: begin
            if (scl_rise) begin
              cnt_q <= cnt_q + 4'd1;
            end else if (scl_fall) begin
              if (cnt_q == 4'd8) begin
                sda_oe <= 1'b0;
                ptr    <= ptr + 1'b1;
                cnt_q  <= '0;
                state  <= ST_MACK;
              end else begin
                sda_oe <= ~tx_q[7];
                tx_q   <= {tx_q[6:0], 1'b0};
              end
            end
          end
          ST_MACK: begin
            if (scl_rise) begin
              if (sda_s) state <= ST_IDLE;
              else       cnt_q <= 4'd1;
            end else if (scl_fall && cnt_q == 4'd1) begin
              tx_q   <= {rd_data[6:0], 1'b0};
              sda_oe <= ~rd_data[7];
              cnt_q  <= '0;
              state  <= ST_TX;
            end
          end
          ST_IDLE: ;
          default: state <= ST_IDLE;
        endcase
      end
    end
  end
endmodule

// File: rtl/i2c_mem_slave.sv
module i2c_mem_slave
  import i2cm_pkg::*;
#(
  parameter int MEM_DEPTH   = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       scl_i,
  input  logic       sda_i,
  input  logic [1:0] sel_a,
  input  logic       sel_fixed,
  input  logic       wp,
  output logic       sda_oe
);
  localparam int ADDR_W = $clog2(MEM_DEPTH);

  logic              scl_s;
  logic              sda_s;
  logic              scl_rise;
  logic              scl_fall;
  logic              start_det;
  logic              stop_det;
  logic              wr_req;
  logic              mem_we;
  logic [7:0]        wr_data;
  logic [7:0]        rd_data;
  logic [ADDR_W-1:0] ptr;
  bus_state_t        state;

  i2cm_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk       (clk),
    .rst       (rst),
    .scl_i     (scl_i),
    .sda_i     (sda_i),
    .scl_s     (scl_s),
    .sda_s     (sda_s),
    .scl_rise  (scl_rise),
    .scl_fall  (scl_fall),
    .start_det (start_det),
    .stop_det  (stop_det)
  );

  i2cm_fsm #(.AW(ADDR_W)) u_fsm (
    .clk       (clk),
    .rst       (rst),
    .scl_rise  (scl_rise),
    .scl_fall  (scl_fall),
    .start_det (start_det),
    .stop_det  (stop_det),
    .sda_s     (sda_s),
    .sel_a     (sel_a),
    .sel_fixed (sel_fixed),
    .rd_data   (rd_data),
    .sda_oe    (sda_oe),
    .wr_req    (wr_req),
    .wr_data   (wr_data),
    .ptr       (ptr),
    .state     (state)
  );

  // protection gates only the array strobe; the bus side is unchanged
  assign mem_we = wr_req & ~wp;

  i2cm_mem #(.DEPTH(MEM_DEPTH), .DW(8)) u_mem (
    .clk   (clk),
    .we    (mem_we),
    .waddr (ptr),
    .wdata (wr_data),
    .raddr (ptr),
    .rdata (rd_data)
  );
endmodule

// File: rtl/i2cm_chk.sv
module i2cm_chk
  import i2cm_pkg::*;
(
  input logic       clk,
  input logic       rst,
  input logic       scl_s,
  input logic       start_det,
  input logic       stop_det,
  input logic       sda_oe,
  input logic       sel_fixed,
  input logic       mem_we,
  input bus_state_t state
);
  assert_start_restart_R1: assert property (@(posedge clk) disable iff (rst)
    start_det |=> (state == ST_DEVADDR && !sda_oe));

  assert_stop_idle_R2: assert property (@(posedge clk) disable iff (rst)
    stop_det |=> (state == ST_IDLE && !sda_oe));

  assert_ack_needs_strap_R5: assert property (@(posedge clk) disable iff (rst)
    (state == ST_DEVACK) |-> sel_fixed);

  assert_write_whole_byte_R7: assert property (@(posedge clk) disable iff (rst)
    mem_we |-> (state == ST_WRACK));

  assert_oe_owner_R9: assert property (@(posedge clk) disable iff (rst)
    sda_oe |-> (state inside {ST_DEVACK, ST_PTRACK, ST_WRACK, ST_TX}));

  assert_oe_scl_low_R11: assert property (@(posedge clk) disable iff (rst)
    (sda_oe != $past(sda_oe)) |-> !scl_s);
endmodule

bind i2c_mem_slave i2cm_chk u_chk (
  .clk       (clk),
  .rst       (rst),
  .scl_s     (scl_s),
  .start_det (start_det),
  .stop_det  (stop_det),
  .sda_oe    (sda_oe),
  .sel_fixed (sel_fixed),
  .mem_we    (mem_we),
  .state     (state)
);

// File: tb/i2c_mem_slave_bench.sv
module i2c_mem_slave_bench;
  localparam int DEPTH = 16;
  localparam int HP    = 12;
  localparam logic [1:0] SEL = 2'b10;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       scl_m = 1'b1;
  logic       sda_m = 1'b1;
  logic [1:0] sel_a = SEL;
  logic       sel_fixed = 1'b1;
  logic       wp = 1'b0;
  logic       sda_oe;
  logic       sda_bus;

  int checks = 0;
  int errors = 0;
  int r11_bad = 0;
  logic prev_oe = 1'b0;

  logic [7:0] model [DEPTH];
  bit         known [DEPTH];

  assign sda_bus = sda_m & ~sda_oe;

  always #5 clk = ~clk;

  i2c_mem_slave u_i2c_mem_slave (
    .clk       (clk),
    .rst       (rst),
    .scl_i     (scl_m),
    .sda_i     (sda_bus),
    .sel_a     (sel_a),
    .sel_fixed (sel_fixed),
    .wp        (wp),
    .sda_oe    (sda_oe)
  );

  // R11: watch for slave line changes while the master holds the clock high
  always @(negedge clk) begin
    if (!rst && (sda_oe !== prev_oe) && scl_m) r11_bad++;
    prev_oe = sda_oe;
  end

  function automatic logic [7:0] dev_byte(input logic [1:0] a, input logic fixed_bit,
                                          input logic rw);
    return {4'b1010, fixed_bit, a, rw};
  endfunction

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_start();
    sda_m = 1'b1; tick(HP);
    scl_m = 1'b1; tick(HP);
    sda_m = 1'b0; tick(HP);
    scl_m = 1'b0; tick(HP);
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; tick(HP);
    scl_m = 1'b1; tick(HP);
    sda_m = 1'b1; tick(HP);
  endtask

  task automatic send_bits(input logic [7:0] b, input int n);
    for (int i = 0; i < n; i++) begin
      sda_m = b[7-i]; tick(HP);
      scl_m = 1'b1;   tick(HP);
      scl_m = 1'b0;   tick(2);
    end
  endtask

  task automatic send_byte(input logic [7:0] b, output bit ack);
    send_bits(b, 8);
    sda_m = 1'b1; tick(HP);
    scl_m = 1'b1; tick(HP/2);
    ack = ~sda_bus;
    tick(HP/2);
    scl_m = 1'b0; tick(2);
  endtask

  task automatic recv_byte(output logic [7:0] b, input bit nack);
    b = '0;
    sda_m = 1'b1;
    for (int i = 0; i < 8; i++) begin
      tick(HP);
      scl_m = 1'b1; tick(HP/2);
      b = {b[6:0], sda_bus};
      tick(HP/2);
      scl_m = 1'b0;
    end
    tick(2);
    sda_m = nack; tick(HP);
    scl_m = 1'b1; tick(HP);
    scl_m = 1'b0; tick(2);
    sda_m = 1'b1;
  endtask

  task automatic wr_seq(input int p, input int n, input bit prot);
    bit ack;
    logic [7:0] d;
    wp = prot;
    bus_start();
    send_byte(dev_byte(SEL, 1'b1, 1'b0), ack); check("R3 address ack", ack, 1);
    send_byte(8'(p), ack);                     check("R6 pointer ack", ack, 1);
    for (int i = 0; i < n; i++) begin
      d = 8'($urandom);
      send_byte(d, ack);
      check(prot ? "R8 protected data ack" : "R7 data ack", ack, 1);
      if (!prot) begin
        model[(p + i) % DEPTH] = d;
        known[(p + i) % DEPTH] = 1'b1;
      end
    end
    bus_stop();
    wp = 1'b0;
  endtask

  task automatic rd_seq(input int p, input int n, input string tag);
    bit ack;
    logic [7:0] d;
    bus_start();
    send_byte(dev_byte(SEL, 1'b1, 1'b0), ack); check("R3 address ack", ack, 1);
    send_byte(8'(p), ack);                     check("R6 pointer ack", ack, 1);
    bus_start();
    send_byte(dev_byte(SEL, 1'b1, 1'b1), ack); check("R9 read address ack", ack, 1);
    for (int i = 0; i < n; i++) begin
      recv_byte(d, i == n - 1);
      if (known[(p + i) % DEPTH])
        check({tag, " read data"}, int'(d), int'(model[(p + i) % DEPTH]));
    end
    bus_stop();
  endtask

  initial begin
    repeat (180000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    bit ack;
    logic [7:0] d;
    void'($urandom(32'd2024));
    for (int i = 0; i < DEPTH; i++) known[i] = 1'b0;
    tick(5);
    rst = 1'b0;
    tick(3);
    check("R12 reset releases line", sda_oe, 0);

    // R6 R7 R9: fill the whole array, then read runs back
    wr_seq(0, DEPTH, 1'b0);
    rd_seq(0, DEPTH, "R9 full");
    wr_seq(3, 4, 1'b0);
    rd_seq(3, 4, "R9 run");

    // R7: pointer wraps from the last location to 0
    wr_seq(DEPTH - 1, 2, 1'b0);
    rd_seq(DEPTH - 1, 2, "R7 wrap");
    rd_seq(0, 1, "R7 wrap target");

    // R8: protected write acknowledged but discarded
    wr_seq(3, 2, 1'b1);
    rd_seq(3, 2, "R8 protected");

    // R4: strap mismatch, no ack on address nor the following byte
    bus_start();
    send_byte(dev_byte(~SEL, 1'b1, 1'b0), ack); check("R4 mismatch address", ack, 0);
    send_byte(8'h00, ack);                      check("R4 ignored byte", ack, 0);
    bus_stop();

    // R3: fixed address bit cleared
    bus_start();
    send_byte(dev_byte(SEL, 1'b0, 1'b0), ack); check("R3 fixed bit zero", ack, 0);
    bus_stop();

    // R5: fixed strap pin low
    sel_fixed = 1'b0;
    bus_start();
    send_byte(dev_byte(SEL, 1'b1, 1'b0), ack); check("R5 strap low", ack, 0);
    bus_stop();
    sel_fixed = 1'b1;

    // R10: after master NACK the slave stays silent
    bus_start();
    send_byte(dev_byte(SEL, 1'b1, 1'b0), ack);
    send_byte(8'd5, ack);
    bus_start();
    send_byte(dev_byte(SEL, 1'b1, 1'b1), ack); check("R10 read address ack", ack, 1);
    recv_byte(d, 1'b1);
    if (known[5]) check("R10 read data", int'(d), int'(model[5]));
    recv_byte(d, 1'b1);
    check("R10 silent after nack", int'(d), 8'hFF);
    bus_stop();

    // R1: repeated start in the middle of a data byte
    bus_start();
    send_byte(dev_byte(SEL, 1'b1, 1'b0), ack);
    send_byte(8'd6, ack);
    send_bits(~model[6], 4);
    bus_start();
    send_byte(dev_byte(SEL, 1'b1, 1'b0), ack); check("R1 restart address ack", ack, 1);
    bus_stop();
    rd_seq(6, 1, "R1 aborted byte");

    // R2: stop in the middle of a data byte
    bus_start();
    send_byte(dev_byte(SEL, 1'b1, 1'b0), ack);
    send_byte(8'd7, ack);
    send_bits(~model[7], 5);
    bus_stop();
    check("R2 line released after stop", sda_oe, 0);
    rd_seq(7, 1, "R2 partial byte");

    // random mix of runs, with and without protection
    for (int k = 0; k < 20; k++) begin
      int p;
      int n;
      bit prot;
      p    = int'($urandom % DEPTH);
      n    = 1 + int'($urandom % 4);
      prot = ($urandom % 4) == 0;
      wr_seq(p, n, prot);
      rd_seq(p, n, prot ? "R8 random" : "R9 random");
    end

    check("R11 line changes while clock high", r11_bad, 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule